// File: doc/BRIEF.md
# Transmit Retry Controller

This block runs the transmit attempts for one frame in a half-duplex Ethernet MAC. The transmit path raises a start request. The block then asks the MAC core for an attempt and tags that request with the index of the attempt. The MAC core answers each attempt with either a clean finish or a collision. After a collision the block waits a programmable number of cycles and asks again. This repeats until the attempt succeeds or the attempt budget is used up, and the block then ends the frame with a one-cycle success pulse or a one-cycle retry-error pulse.

While retransmission is still possible, the block holds a protect signal towards the transmit FIFO so that the first 64 bytes of the frame are not overwritten. A single-attempt mode allows only one attempt, and in that mode the protect signal is never raised because a retransmission cannot happen. For testing the collision path, a force-collision input turns the end of every attempt into a collision. It only does this while internal loopback is active, and a frame run in that way always ends with a retry error. The mode, force-collision and loopback inputs are sampled once, when the frame starts.

Top module: `rtx_retry_ctrl`

## Requirements
- R1: During and after a synchronous reset, xmit_req_o, done_o, retry_err_o and fifo_hold_o are 0 and attempt_o is 0.
- R2: A start_i sampled while idle makes xmit_req_o high for exactly one cycle, in the cycle after the start, with attempt_o = 0.
- R3: Each collision that does not end the frame increments attempt_o by one. The next xmit_req_o pulse then rises exactly backoff_i cycles after the cycle in which the collision was sampled (a value of 0 gives the next cycle).
- R4: With no_retry_i = 0, at most MAX_ATT (16) attempts are made. A collision on the last one gives a retry_err_o pulse of exactly one cycle, and no further request follows.
- R5: With no_retry_i = 1, exactly one attempt is made, a collision on it gives a retry_err_o pulse, and fifo_hold_o stays 0 for the whole frame.
- R6: With no_retry_i = 0, fifo_hold_o is 1 from the first request until the frame ends. A clean finish (att_done_i with no collision in effect) gives a one-cycle done_o pulse, and fifo_hold_o falls in that same cycle.
- R7: With force_coll_i = 1 and int_loop_i = 1 at start, every attempt end, including att_done_i, counts as a collision, so the frame ends with retry_err_o after the full attempt budget of the selected mode.
- R8: With force_coll_i = 1 but int_loop_i = 0, the force input has no effect, and att_done_i ends the frame with done_o.
- R9: A start_i raised while a frame is in progress is ignored: the attempt numbering and the number of requests for the current frame do not change.
- R10: done_o and retry_err_o are never high in the same cycle, and each frame yields exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Frame start request from the transmit path |
| no_retry_i | input | 1 | 1 selects single-attempt mode, sampled at start |
| force_coll_i | input | 1 | Collision injection for test, sampled at start |
| int_loop_i | input | 1 | MAC is in internal loopback, sampled at start |
| backoff_i | input | BO_W | Wait in cycles between a collision and the next request |
| att_done_i | input | 1 | Current attempt finished without collision |
| att_coll_i | input | 1 | Current attempt hit a collision |
| xmit_req_o | output | 1 | One-cycle request to start an attempt |
| attempt_o | output | CNT_W | Index of the current attempt, 0 based |
| fifo_hold_o | output | 1 | Keep the frame head in the transmit FIFO |
| done_o | output | 1 | One-cycle pulse, frame sent |
| retry_err_o | output | 1 | One-cycle pulse, attempts exhausted |

## Verification
The bench builds the block with its default parameters, MAX_ATT = 16 and an 8-bit backoff. The backoff is programmed small (0 to 3 cycles) for most frames, so full 16-attempt frames, both the forced and the plain collision runs, finish in a few hundred cycles. This covers the attempt-index boundary at 15, which must end the frame, next to a frame that succeeds on its 16th attempt. A zero backoff exercises the direct collision-to-request path, and nonzero values exercise the wait counter.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQ     = 2'd1,
        ST_WAIT    = 2'd2,
        ST_BACKOFF = 2'd3
    } rtx_state_e;

    // frame configuration captured when the frame starts
    typedef struct packed {
        logic single;    // one attempt only
        logic force_eff; // force-collision qualified by internal loopback
    } rtx_cfg_t;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_DONE = 2'd1,
        OUT_ERR  = 2'd2
    } rtx_outcome_e;

    function automatic rtx_cfg_t make_cfg(input logic no_retry,
                                          input logic force_coll,
                                          input logic int_loop);
        rtx_cfg_t c;
        c.single    = no_retry;
        c.force_eff = force_coll & int_loop;
        return c;
    endfunction

    // decide how an attempt end is treated
    function automatic logic eff_collision(input rtx_cfg_t c,
                                           input logic done,
                                           input logic coll);
        return coll | (c.force_eff & done);
    endfunction

endpackage

// File: rtl/rtx_attempt_ctr.sv
module rtx_attempt_ctr #(
    parameter int MAX_ATT = 16,
    localparam int CNT_W  = (MAX_ATT > 1) ? $clog2(MAX_ATT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_ATT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign at_last = (cnt_q == LAST);

    // R3: the index never steps past the last attempt
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        inc |-> (cnt_q != LAST));

endmodule

// File: rtl/rtx_backoff_timer.sv
module rtx_backoff_timer #(
    parameter int BO_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BO_W-1:0] load_val,
    input  logic            run,
    output logic            expired
);
    logic [BO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: a running wait only counts downwards
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rtx_retry_ctrl.sv
module rtx_retry_ctrl
    import rtx_pkg::*;
#(
    parameter int MAX_ATT = 16,
    parameter int BO_W    = 8,
    localparam int CNT_W  = (MAX_ATT > 1) ? $clog2(MAX_ATT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             no_retry_i,
    input  logic             force_coll_i,
    input  logic             int_loop_i,
    input  logic [BO_W-1:0]  backoff_i,
    input  logic             att_done_i,
    input  logic             att_coll_i,
    output logic             xmit_req_o,
    output logic [CNT_W-1:0] attempt_o,
    output logic             fifo_hold_o,
    output logic             done_o,
    output logic             retry_err_o
);
    rtx_state_e   st_q, st_d;
    rtx_cfg_t     cfg_q;
    rtx_outcome_e out_q, out_d;
    logic         hold_q;

    logic ctr_clr, ctr_inc, ctr_last;
    logic tmr_load, tmr_expired;
    logic att_end, coll_eff, final_att;

    assign att_end   = att_done_i | att_coll_i;
    assign coll_eff  = eff_collision(cfg_q, att_done_i, att_coll_i);
    assign final_att = cfg_q.single | ctr_last;

    rtx_attempt_ctr #(.MAX_ATT(MAX_ATT)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctr_clr),
        .inc     (ctr_inc),
        .cnt     (attempt_o),
        .at_last (ctr_last)
    );

    rtx_backoff_timer #(.BO_W(BO_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (backoff_i - 1'b1),
        .run      (st_q == ST_BACKOFF),
        .expired  (tmr_expired)
    );

    always_comb begin
        st_d     = st_q;
        out_d    = OUT_NONE;
        ctr_clr  = 1'b0;
        ctr_inc  = 1'b0;
        tmr_load = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d    = ST_REQ;
                    ctr_clr = 1'b1;
                end
            end
            ST_REQ: begin
                st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (att_end) begin
                    if (!coll_eff) begin
                        out_d = OUT_DONE;
                        st_d  = ST_IDLE;
                    end else if (final_att) begin
                        out_d = OUT_ERR;
                        st_d  = ST_IDLE;
                    end else begin
                        ctr_inc = 1'b1;
                        if (backoff_i == '0) begin
                            st_d = ST_REQ;
                        end else begin
                            st_d     = ST_BACKOFF;
                            tmr_load = 1'b1;
                        end
                    end
                end
            end
            ST_BACKOFF: begin
                if (tmr_expired) begin
                    st_d = ST_REQ;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            out_q  <= OUT_NONE;
            cfg_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            out_q <= out_d;
            if (st_q == ST_IDLE && start_i) begin
                cfg_q  <= make_cfg(no_retry_i, force_coll_i, int_loop_i);
                hold_q <= !no_retry_i;
            end else if (out_d != OUT_NONE) begin
                hold_q <= 1'b0;
            end
        end
    end

    assign xmit_req_o  = (st_q == ST_REQ);
    assign fifo_hold_o = hold_q;
    assign done_o      = (out_q == OUT_DONE);
    assign retry_err_o = (out_q == OUT_ERR);

    // R10: outcomes are exclusive
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(done_o && retry_err_o));

    // R4: retry error lasts one cycle
    a_r4_err_pulse: assert property (@(posedge clk) disable iff (rst)
        retry_err_o |=> !retry_err_o);

    // R6: protection is released when the frame completes
    a_r6_done_release: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !fifo_hold_o);

    // R5: single-attempt frames never hold the FIFO head
    a_r5_single_no_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && cfg_q.single) |-> !fifo_hold_o);

    // R2: each request is a single-cycle pulse
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
        xmit_req_o |=> !xmit_req_o);

endmodule

// File: tb/sim_rtx_retry_ctrl.sv
module sim_rtx_retry_ctrl;
    localparam int MAX_ATT = 16;
    localparam int BO_W    = 8;
    localparam int CNT_W   = $clog2(MAX_ATT);

    typedef struct {
        bit err;
        int atts;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, no_retry_i = 0, force_coll_i = 0, int_loop_i = 0;
    logic [BO_W-1:0] backoff_i = '0;
    logic att_done_i = 0, att_coll_i = 0;
    logic xmit_req_o, fifo_hold_o, done_o, retry_err_o;
    logic [CNT_W-1:0] attempt_o;

    int total = 0;
    int bad = 0;
    int req_seen = 0;
    bit finished = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    rtx_retry_ctrl #(.MAX_ATT(MAX_ATT), .BO_W(BO_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .no_retry_i(no_retry_i),
        .force_coll_i(force_coll_i), .int_loop_i(int_loop_i),
        .backoff_i(backoff_i), .att_done_i(att_done_i), .att_coll_i(att_coll_i),
        .xmit_req_o(xmit_req_o), .attempt_o(attempt_o), .fifo_hold_o(fifo_hold_o),
        .done_o(done_o), .retry_err_o(retry_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: pops the expected outcome whenever the design ends a frame
    always @(negedge clk) begin
        if (!rst && xmit_req_o) req_seen++;
        if (!rst && (done_o || retry_err_o)) begin
            chk(!(done_o && retry_err_o), "R10 exclusive", int'(done_o), 0);
            chk(!fifo_hold_o, "R6 hold released at end", int'(fifo_hold_o), 0);
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected outcome", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(retry_err_o == e.err, e.err ? "R4 retry error" : "R6 done",
                    int'(retry_err_o), int'(e.err));
                chk(req_seen == e.atts, "R4 attempt count", req_seen, e.atts);
            end
            req_seen = 0;
        end
    end

    task automatic wait_req();
        int n = 0;
        while (!xmit_req_o && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    // driver: one frame, ncoll collisions reported before a clean finish
    task automatic frame(input int ncoll, input bit nr, input bit fc,
                         input bit lp, input int bo, input bit poke, input string tag);
        exp_t e;
        bit forced = fc && lp;
        int budget = nr ? 1 : MAX_ATT;
        if (forced || ncoll >= budget) begin
            e.err = 1; e.atts = budget;
        end else begin
            e.err = 0; e.atts = ncoll + 1;
        end
        exp_q.push_back(e);
        @(negedge clk);
        no_retry_i = nr; force_coll_i = fc; int_loop_i = lp;
        backoff_i = BO_W'(bo); start_i = 1;
        @(negedge clk);
        start_i = 0;
        for (int k = 0; k < e.atts; k++) begin
            wait_req();
            chk(xmit_req_o, {tag, " R2 request present"}, int'(xmit_req_o), 1);
            chk(attempt_o == CNT_W'(k), {tag, " R3 attempt index"}, int'(attempt_o), k);
            chk(fifo_hold_o == !nr, nr ? {tag, " R5 no hold"} : {tag, " R6 hold"},
                int'(fifo_hold_o), int'(!nr));
            @(negedge clk);
            if (poke) begin
                start_i = 1;
                @(negedge clk);
                start_i = 0;
            end
            if (k < ncoll || (forced && k % 2 == 0)) att_coll_i = 1;
            else att_done_i = 1;
            if (k < e.atts - 1) begin
                int gap = 0;
                forever begin
                    @(negedge clk);
                    att_coll_i = 0; att_done_i = 0;
                    if (xmit_req_o || gap > 300) break;
                    gap++;
                end
                chk(gap == bo, {tag, " R3 backoff gap"}, gap, bo);
            end else begin
                @(negedge clk);
                att_coll_i = 0; att_done_i = 0;
            end
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!xmit_req_o, {tag, " R4 no request after end"}, int'(xmit_req_o), 0);
        end
        chk(exp_q.size() == 0, {tag, " R10 outcome seen"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!xmit_req_o && !done_o && !retry_err_o && !fifo_hold_o && attempt_o == 0,
            "R1 reset state", int'(fifo_hold_o), 0);
        rst = 0;
        @(negedge clk);
        chk(!xmit_req_o && !fifo_hold_o, "R1 idle after reset", int'(xmit_req_o), 0);

        frame(0,  0, 0, 0, 0, 0, "first try R6");
        frame(3,  0, 0, 0, 2, 0, "three coll R3");
        frame(16, 0, 0, 0, 0, 0, "budget R4");
        frame(15, 0, 0, 0, 1, 0, "last try ok R4");
        frame(1,  1, 0, 0, 3, 0, "single coll R5");
        frame(0,  1, 0, 0, 3, 0, "single ok R5");
        frame(0,  0, 1, 1, 1, 0, "forced multi R7");
        frame(0,  1, 1, 1, 0, 0, "forced single R7");
        frame(0,  0, 1, 0, 0, 0, "force no loop R8");
        frame(2,  0, 0, 0, 3, 1, "restart ignored R9");

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule